// File: doc/BRIEF.md
# Shared Bus Resolver

This block replaces a net with several drivers inside a synthesizable design, where tri-state drivers have been rewritten as ordinary logic. Each of N drivers supplies an enable bit and a W-bit word. The block combines the enabled words bit by bit under a rule chosen at compile time. The rules are plain, wired-AND, wired-OR, pull-low and pull-high. Everything is two-valued: a clash or an undriven state is reported on flags instead of appearing as unknown or high-impedance values.

The resolved word, the per-bit clash mask, the undriven flag and the multiple-enable flag are all combinational from the inputs. Only the error flag is registered. It records any clash or multiple-enable event until software-independent logic sends a one-cycle clear pulse, or until reset.

Driver k occupies bits `[k*W +: W]` of the flattened data input.

Top module: `bus_resolver`

## Requirements
- R1: A driver whose enable bit is 0 has no effect on any output, whatever its data.
- R2: When exactly one driver is enabled, `bus_o` equals that driver's word in every mode, and `conflict_o` and `float_o` are 0.
- R3: In plain mode, enabled drivers that agree on a bit give that value. A bit where enabled drivers disagree sets the matching `conflict_o` bit. Its value is 1 with the ones fallback, or the bit of the lowest-index enabled driver with the priority fallback.
- R4: In wired-AND mode, a bit is 0 if any enabled driver presents 0, and 1 otherwise.
- R5: In wired-OR mode, a bit is 1 if any enabled driver presents 1, and 0 otherwise.
- R6: With no driver enabled, `bus_o` is all zeros in pull-low mode and all ones in pull-high mode, and `float_o` stays 0 in both modes.
- R7: With no driver enabled in plain, wired-AND or wired-OR mode, `float_o` is 1 and `bus_o` is all ones. `float_o` is 0 whenever any enable is set.
- R8: Pull-low and pull-high modes follow the plain-mode clash rule with the ones fallback. `conflict_o` is always zero in wired-AND and wired-OR modes.
- R9: `multi_en_o` is 1 exactly when more than one enable bit is set, independent of the data.
- R10: `err_o` becomes 1 after any clock edge at which a `conflict_o` bit or `multi_en_o` was 1. It then holds until an edge with `clr_i` high and no new clash or multiple-enable event; a new event wins over a clear in the same cycle.
- R11: `err_o` is 0 while and immediately after `rst_ni` (asynchronous, active low) is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the error flag |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | N_DRV | Per-driver enable |
| data_i | input | N_DRV*W | Driver words, driver k at [k*W +: W] |
| clr_i | input | 1 | One-cycle clear of the error flag |
| bus_o | output | W | Resolved word |
| conflict_o | output | W | Per-bit clash mask |
| float_o | output | 1 | No driver enabled in a non-pull mode |
| multi_en_o | output | 1 | More than one enable asserted |
| err_o | output | 1 | Sticky clash / multiple-enable flag |

## Verification
The bound checker watches several rules on every cycle. These are the multiple-enable flag against the enable population count, the undriven and pull values with no enables set, the absence of clashes in wired modes or with fewer than two drivers, and the set, hold and clear rules of the sticky flag. The bench alone can show the value of each resolved bit under mixed agreeing and clashing drivers. It also shows that the priority fallback selects the lowest-index driver and that disabled drivers' data is ignored. It does this by running six mode and fallback variants side by side against a behavioural model.

// File: rtl/bus_res_pkg.sv
package bus_res_pkg;
  typedef enum logic [2:0] {
    RES_PLAIN = 3'd0,
    RES_WAND  = 3'd1,
    RES_WOR   = 3'd2,
    RES_PULL0 = 3'd3,
    RES_PULL1 = 3'd4
  } res_mode_e;

  typedef enum logic {
    FB_ONES = 1'b0,
    FB_PRIO = 1'b1
  } fb_mode_e;
endpackage

// File: rtl/bus_bit_res.sv
module bus_bit_res import bus_res_pkg::*; #(
  parameter int        N_DRV = 4,
  parameter res_mode_e MODE  = RES_PLAIN,
  parameter fb_mode_e  FB    = FB_ONES
) (
  input  logic [N_DRV-1:0] en_i,
  input  logic [N_DRV-1:0] bit_i,
  input  logic             pri_bit_i,
  output logic             val_o,
  output logic             conf_o
);
  logic any_en, has_one, has_zero, clash, fb_val;

  assign any_en   = |en_i;
  assign has_one  = |(en_i & bit_i);
  assign has_zero = |(en_i & ~bit_i);
  assign clash    = has_one & has_zero;
  // pull modes always use the ones fallback on a clash
  assign fb_val   = (FB == FB_PRIO && MODE == RES_PLAIN) ? pri_bit_i : 1'b1;

  always_comb begin
    val_o  = 1'b1;
    conf_o = 1'b0;
    case (MODE)
      RES_WAND: val_o = any_en ? ~has_zero : 1'b1;
      RES_WOR:  val_o = any_en ? has_one : 1'b1;
      default: begin
        if (!any_en) begin
          val_o = (MODE == RES_PULL0) ? 1'b0 : 1'b1;
        end else if (clash) begin
          val_o  = fb_val;
          conf_o = 1'b1;
        end else begin
          val_o = has_one;
        end
      end
    endcase
  end
endmodule

// File: rtl/bus_excl_det.sv
module bus_excl_det #(
  parameter int N_DRV = 4
) (
  input  logic [N_DRV-1:0] en_i,
  output logic             multi_o
);
  localparam int CW = $clog2(N_DRV + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < N_DRV; k++) cnt = cnt + CW'(en_i[k]);
  end

  assign multi_o = (cnt > CW'(1));
endmodule

// File: rtl/bus_err_sticky.sv
module bus_err_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (err_q & ~clr_i) | hit_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/bus_resolver.sv
module bus_resolver import bus_res_pkg::*; #(
  parameter int        N_DRV = 4,
  parameter int        W     = 8,
  parameter res_mode_e MODE  = RES_PLAIN,
  parameter fb_mode_e  FB    = FB_ONES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_DRV-1:0]   en_i,
  input  logic [N_DRV*W-1:0] data_i,
  input  logic               clr_i,
  output logic [W-1:0]       bus_o,
  output logic [W-1:0]       conflict_o,
  output logic               float_o,
  output logic               multi_en_o,
  output logic               err_o
);
  localparam logic CAN_FLOAT = (MODE == RES_PLAIN) || (MODE == RES_WAND) || (MODE == RES_WOR);

  logic [W-1:0] pri_w;
  logic         hit;

  // word of the lowest-index enabled driver
  always_comb begin
    pri_w = '0;
    for (int k = N_DRV - 1; k >= 0; k--) begin
      if (en_i[k]) pri_w = data_i[k*W +: W];
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N_DRV-1:0] col;
    for (genvar k = 0; k < N_DRV; k++) begin : g_col
      assign col[k] = data_i[k*W + b];
    end
    bus_bit_res #(.N_DRV(N_DRV), .MODE(MODE), .FB(FB)) u_bit (
      .en_i      (en_i),
      .bit_i     (col),
      .pri_bit_i (pri_w[b]),
      .val_o     (bus_o[b]),
      .conf_o    (conflict_o[b])
    );
  end

  bus_excl_det #(.N_DRV(N_DRV)) u_excl (
    .en_i    (en_i),
    .multi_o (multi_en_o)
  );

  assign float_o = CAN_FLOAT & ~(|en_i);
  assign hit     = (|conflict_o) | multi_en_o;

  bus_err_sticky u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (clr_i),
    .err_o  (err_o)
  );
endmodule

// File: rtl/bus_resolver_chk.sv
module bus_resolver_chk import bus_res_pkg::*; #(
  parameter int        N_DRV = 4,
  parameter int        W     = 8,
  parameter res_mode_e MODE  = RES_PLAIN
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DRV-1:0] en_i,
  input logic             clr_i,
  input logic [W-1:0]     bus_o,
  input logic [W-1:0]     conflict_o,
  input logic             float_o,
  input logic             multi_en_o,
  input logic             err_o
);
  localparam logic [W-1:0] IDLE_VAL = (MODE == RES_PULL0) ? '0 : '1;
  localparam logic WIRED = (MODE == RES_WAND) || (MODE == RES_WOR);

  // R9
  multi_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_en_o == ($countones(en_i) > 1));

  // R7
  float_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_o |-> (en_i == '0));

  // R6
  idle_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (bus_o == IDLE_VAL));

  // R8
  no_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WIRED || $countones(en_i) < 2) |-> (conflict_o == '0));

  // R10
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|conflict_o) || multi_en_o) |=> err_o);

  // R10
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);

  // R10
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|conflict_o) && !multi_en_o) |=> !err_o);
endmodule

bind bus_resolver bus_resolver_chk #(.N_DRV(N_DRV), .W(W), .MODE(MODE)) u_chk (.*);

// File: tb/tb_bus_resolver.sv
module tb_bus_resolver;
  import bus_res_pkg::*;
  localparam int N  = 3;
  localparam int W  = 4;
  localparam int NI = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]   en = '0;
  logic [N*W-1:0] data = '0;
  logic clr = 1'b0;

  logic [W-1:0] bus [NI];
  logic [W-1:0] conf [NI];
  logic flt [NI];
  logic multi [NI];
  logic err [NI];

  int checks = 0;
  int failures = 0;
  logic exp_err [NI];
  logic pend_hit [NI];
  bit done = 0;

  always #5 clk = ~clk;

  bus_resolver #(.N_DRV(N), .W(W), .MODE(RES_PLAIN), .FB(FB_ONES)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .data_i(data), .clr_i(clr),
    .bus_o(bus[0]), .conflict_o(conf[0]), .float_o(flt[0]), .multi_en_o(multi[0]), .err_o(err[0]));
  bus_resolver #(.N_DRV(N), .W(W), .MODE(RES_PLAIN), .FB(FB_PRIO)) dut_prio (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .data_i(data), .clr_i(clr),
    .bus_o(bus[1]), .conflict_o(conf[1]), .float_o(flt[1]), .multi_en_o(multi[1]), .err_o(err[1]));
  bus_resolver #(.N_DRV(N), .W(W), .MODE(RES_WAND), .FB(FB_ONES)) dut_wand (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .data_i(data), .clr_i(clr),
    .bus_o(bus[2]), .conflict_o(conf[2]), .float_o(flt[2]), .multi_en_o(multi[2]), .err_o(err[2]));
  bus_resolver #(.N_DRV(N), .W(W), .MODE(RES_WOR), .FB(FB_ONES)) dut_wor (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .data_i(data), .clr_i(clr),
    .bus_o(bus[3]), .conflict_o(conf[3]), .float_o(flt[3]), .multi_en_o(multi[3]), .err_o(err[3]));
  bus_resolver #(.N_DRV(N), .W(W), .MODE(RES_PULL0), .FB(FB_ONES)) dut_pd (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .data_i(data), .clr_i(clr),
    .bus_o(bus[4]), .conflict_o(conf[4]), .float_o(flt[4]), .multi_en_o(multi[4]), .err_o(err[4]));
  bus_resolver #(.N_DRV(N), .W(W), .MODE(RES_PULL1), .FB(FB_ONES)) dut_pu (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .data_i(data), .clr_i(clr),
    .bus_o(bus[5]), .conflict_o(conf[5]), .float_o(flt[5]), .multi_en_o(multi[5]), .err_o(err[5]));

  task automatic check(input string req, input int id, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s inst%0d %s actual=%h expected=%h", req, id, what, act, exp);
    end
  endtask

  // behavioural reference for instance id (0 plain/ones, 1 plain/prio, 2 and, 3 or, 4 pull-low, 5 pull-high)
  task automatic model(input int id, output logic [W-1:0] eb, output logic [W-1:0] ec,
                       output logic ef, output logic em, output string tag);
    int cnt = 0;
    int first = -1;
    for (int k = 0; k < N; k++) if (en[k]) begin
      cnt++;
      if (first < 0) first = k;
    end
    ec = '0;
    ef = (cnt == 0) && (id <= 3);
    em = (cnt > 1);
    for (int b = 0; b < W; b++) begin
      bit o1 = 0;
      bit o0 = 0;
      for (int k = 0; k < N; k++) if (en[k]) begin
        if (data[k*W+b]) o1 = 1; else o0 = 1;
      end
      if (cnt == 0) eb[b] = (id == 4) ? 1'b0 : 1'b1;
      else if (id == 2) eb[b] = !o0;
      else if (id == 3) eb[b] = o1;
      else if (o1 && o0) begin
        ec[b] = 1'b1;
        eb[b] = (id == 1) ? data[first*W+b] : 1'b1;
      end else eb[b] = o1;
    end
    if (cnt == 0) tag = (id <= 3) ? "R7" : "R6";
    else if (cnt == 1) tag = "R2";
    else if (id <= 1) tag = "R3";
    else if (id == 2) tag = "R4";
    else if (id == 3) tag = "R5";
    else tag = "R8";
  endtask

  task automatic step(input logic [N-1:0] e, input logic [N*W-1:0] d, input logic c);
    logic [W-1:0] eb, ec;
    logic ef, em;
    string tag;
    @(negedge clk);
    for (int i = 0; i < NI; i++) check("R10", i, "err", {3'b0, err[i]}, {3'b0, exp_err[i]});
    en = e; data = d; clr = c;
    #1;
    for (int i = 0; i < NI; i++) begin
      model(i, eb, ec, ef, em, tag);
      check(tag, i, "bus", bus[i], eb);
      check("R8", i, "conflict", conf[i], ec);
      check("R7", i, "float", {3'b0, flt[i]}, {3'b0, ef});
      check("R9", i, "multi", {3'b0, multi[i]}, {3'b0, em});
      pend_hit[i] = (ec != '0) || em;
    end
    @(posedge clk);
    for (int i = 0; i < NI; i++) exp_err[i] = (exp_err[i] & ~c) | pend_hit[i];
  endtask

  function automatic logic [N*W-1:0] pk(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    return {c, b, a};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ref_bus;
    for (int i = 0; i < NI; i++) exp_err[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int i = 0; i < NI; i++) check("R11", i, "err in reset", {3'b0, err[i]}, 4'h0);
    rst_ni = 1'b1;

    step(3'b000, pk(4'h3, 4'h5, 4'h9), 1'b0);         // R6 R7 idle
    step(3'b001, pk(4'hA, 4'h5, 4'h0), 1'b0);         // R2
    step(3'b010, pk(4'hA, 4'h6, 4'h0), 1'b0);
    step(3'b100, pk(4'h0, 4'h0, 4'hC), 1'b0);
    // R1: only driver 0 enabled, other drivers' data swept
    step(3'b001, pk(4'h5, 4'h0, 4'h0), 1'b0);
    ref_bus = bus[0];
    for (int v = 1; v < 4; v++) begin
      step(3'b001, pk(4'h5, 4'(v * 5), 4'(~v)), 1'b0);
      check("R1", 0, "bus vs disabled data", bus[0], ref_bus);
    end
    step(3'b011, pk(4'hA, 4'hA, 4'h1), 1'b0);         // agree, multi only
    step(3'b000, '0, 1'b0);                            // R10 hold
    step(3'b000, '0, 1'b1);                            // R10 clear
    step(3'b000, '0, 1'b0);
    step(3'b011, pk(4'hA, 4'h5, 4'h0), 1'b0);         // full clash, prio -> A
    step(3'b110, pk(4'h0, 4'h3, 4'hC), 1'b1);         // clash + clear: set wins, prio -> 3
    step(3'b111, pk(4'hF, 4'h9, 4'h1), 1'b0);
    step(3'b101, pk(4'h6, 4'h0, 4'h6), 1'b1);         // multi agree, clear loses
    step(3'b100, pk(4'h0, 4'h0, 4'h7), 1'b1);
    step(3'b000, '0, 1'b0);

    // R11 asynchronous reset with flags set
    step(3'b111, pk(4'h1, 4'h2, 4'h4), 1'b0);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    for (int i = 0; i < NI; i++) begin
      check("R11", i, "err after reset", {3'b0, err[i]}, 4'h0);
      exp_err[i] = 1'b0;
    end
    en = '0; clr = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    for (int n = 0; n < 300; n++) begin
      step(N'($urandom), N*W'($urandom), ($urandom % 5) == 0);
    end
    @(negedge clk);
    for (int i = 0; i < NI; i++) check("R10", i, "err final", {3'b0, err[i]}, {3'b0, exp_err[i]});

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule